// File: doc/BRIEF.md
# BF16 Multi-Dimension Reduce Unit

This unit folds a dense four-dimensional BF16 tensor down along a chosen group of its innermost dimensions. A command gives the operation (sum or maximum), a selector that picks how many inner dimensions are folded together, the four dimension sizes, a negate flag and the output format. The elements then stream in one per accepted cycle, innermost dimension first. Each time a full group has arrived, the unit emits one reduced value.

Sums are carried in an FP32 accumulator. The result leaves either as FP32 or rounded to BF16. The maximum is exact, propagates NaN, and treats the two signed zeros as equal. A malformed command is refused with a one-cycle error pulse, and the unit stays idle.

Top module: `bf16_reduce_unit`

## Requirements
- R1: Opcode 0x8C selects summation and opcode 0x8D selects maximum; any other opcode is refused.
- R2: The shape is packed as cmd_shape = {w, z, y, x}, with x in the lowest DIM_W bits, and elements arrive x-fastest. Selector 0 folds x, 1 folds x·y, 2 folds x·y·z and 3 folds all four. One result is emitted per group, in the cycle after the group's last element is accepted, and total/group results are produced in all.
- R3: When cmd_neg is set, each non-NaN result has its sign flipped before output; a NaN result is not altered.
- R4: With cmd_fp32 = 1, out_data carries the FP32 result. With cmd_fp32 = 0, out_data[15:0] carries the BF16 result and out_data[31:16] is zero.
- R5: Sums accumulate in FP32 with round-to-nearest-even at every addition. A BF16 output is rounded from FP32 with nearest-even, ties going to the even BF16 value.
- R6: A NaN input makes the group result the canonical quiet NaN (0x7FC00000, or 0x7FC0 as BF16), for either operation. Adding +inf and -inf also gives that NaN.
- R7: In a maximum, +0 and -0 compare equal, and the one seen first is kept.
- R8: A command with a zero dimension size, a selector above 3 or an unknown opcode raises cmd_err for exactly the next cycle, produces no result and leaves the unit ready for a new command.
- R9: After reset, cmd_ready = 1, in_ready = 0, out_valid = 0 and cmd_err = 0. in_ready is high only while a command is in progress, so elements offered when idle are ignored. The unit returns to idle once all elements of the tensor are taken.
- R10: BF16 inputs with a zero exponent field (subnormals) are taken as zero of the same sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_op | input | 8 | Operation code |
| cmd_sel | input | 3 | Folded-dimension selector |
| cmd_shape | input | 4*DIM_W | Dimension sizes {w,z,y,x} |
| cmd_neg | input | 1 | Negate each result |
| cmd_fp32 | input | 1 | 1 = FP32 output, 0 = BF16 output |
| cmd_err | output | 1 | One-cycle pulse for a refused command |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element accepted when valid |
| in_data | input | 16 | BF16 element |
| out_valid | output | 1 | Result valid for one cycle |
| out_data | output | 32 | Result value |

## Verification
The bench checks groupings that emit several results per tensor. A group counter tied to the wrong dimension product would give the wrong number of results, or would mix partial sums across groups. It also checks the exact round-to-nearest-even tie on BF16 output and a large cancellation (256 + 1 − 256). Truncation would show up in the tie case, and a lost guard bit in the cancellation. For maximum it sends a NaN in mid-group and both orders of signed zeros. A design that skips NaN or orders −0 below +0 would return the wrong bit pattern. It also sends three kinds of refused command and a subnormal pair, and checks that none of them leaves a result behind.

// File: rtl/bf16r_pkg.sv
package bf16r_pkg;

  localparam logic [7:0]  OPC_SUM = 8'h8C;
  localparam logic [7:0]  OPC_MAX = 8'h8D;
  localparam logic [31:0] QNAN32  = 32'h7FC0_0000;
  localparam logic [15:0] QNAN16  = 16'h7FC0;

  function automatic logic f32_is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  // BF16 to FP32; subnormals become signed zero
  function automatic logic [31:0] bf16_widen(input logic [15:0] h);
    if (h[14:7] == 8'd0) return {h[15], 31'd0};
    return {h, 16'd0};
  endfunction

  // FP32 to BF16 with round to nearest even
  function automatic logic [15:0] f32_to_bf16(input logic [31:0] v);
    logic up;
    if (f32_is_nan(v)) return QNAN16;
    up = v[15] & (v[16] | (|v[14:0]));
    return v[31:16] + {15'd0, up};
  endfunction

  // strict greater-than on non-NaN values, zeros of either sign equal
  function automatic logic f32_gt(input logic [31:0] a, input logic [31:0] b);
    if ((a[30:0] == 31'd0) && (b[30:0] == 31'd0)) return 1'b0;
    if (a[31] != b[31]) return !a[31];
    if (!a[31]) return a[30:0] > b[30:0];
    return a[30:0] < b[30:0];
  endfunction

  function automatic logic [31:0] f32_max_step(input logic [31:0] acc, input logic [31:0] x);
    if (f32_is_nan(acc)) return acc;
    if (f32_is_nan(x)) return x;
    return f32_gt(x, acc) ? x : acc;
  endfunction

  // FP32 add, nearest-even, subnormal results flushed to signed zero
  function automatic logic [31:0] f32_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] big, sml;
    logic [7:0]  d;
    logic [26:0] mb, ms, msh, lost;
    logic [27:0] s;
    logic [8:0]  e;
    logic [4:0]  lz;
    logic        found;
    logic        up;
    logic [24:0] r;
    if (f32_is_nan(a) || f32_is_nan(b)) return QNAN32;
    if (a[30:23] == 8'hFF) begin
      if ((b[30:23] == 8'hFF) && (a[31] != b[31])) return QNAN32;
      return a;
    end
    if (b[30:23] == 8'hFF) return b;
    if (a[30:23] == 8'd0) begin
      if (b[30:23] == 8'd0) return {a[31] & b[31], 31'd0};
      return b;
    end
    if (b[30:23] == 8'd0) return a;
    if (a[30:0] >= b[30:0]) begin big = a; sml = b; end
    else begin big = b; sml = a; end
    d  = big[30:23] - sml[30:23];
    mb = {1'b1, big[22:0], 3'b000};
    ms = {1'b1, sml[22:0], 3'b000};
    if (d >= 8'd27) msh = 27'd1;
    else begin
      msh  = ms >> d;
      lost = ms & ((27'd1 << d) - 27'd1);
      if (lost != 27'd0) msh[0] = 1'b1;
    end
    e = {1'b0, big[30:23]};
    if (big[31] == sml[31]) begin
      s = {1'b0, mb} + {1'b0, msh};
      if (s[27]) begin
        s = {1'b0, s[27:1]} | {27'd0, s[0]};
        e = e + 9'd1;
      end
    end else begin
      s = {1'b0, mb} - {1'b0, msh};
      if (s == 28'd0) return 32'd0;
      lz = 5'd0;
      found = 1'b0;
      for (int i = 0; i < 27; i++) begin
        if (!found) begin
          if (s[26-i]) found = 1'b1;
          else lz = lz + 5'd1;
        end
      end
      s = s << lz;
      if (e <= {4'd0, lz}) return {big[31], 31'd0};
      e = e - {4'd0, lz};
    end
    up = s[2] & (s[1] | s[0] | s[3]);
    r  = {1'b0, s[26:3]} + {24'd0, up};
    if (r[24]) begin
      r = r >> 1;
      e = e + 9'd1;
    end
    if (e >= 9'd255) return {big[31], 8'hFF, 23'd0};
    return {big[31], e[7:0], r[22:0]};
  endfunction

endpackage

// File: rtl/bf16r_cmd_check.sv
module bf16r_cmd_check
  import bf16r_pkg::*;
#(
  parameter int DIM_W = 8,
  localparam int CNT_W = 4 * DIM_W
) (
  input  logic [7:0]         op,
  input  logic [2:0]         sel,
  input  logic [4*DIM_W-1:0] shape,
  output logic               ok,
  output logic               is_max,
  output logic [CNT_W-1:0]   grp_size,
  output logic [CNT_W-1:0]   total
);
  logic [DIM_W-1:0] dim  [4];
  logic [CNT_W-1:0] prod [4];
  logic [3:0]       dim_nz;

  for (genvar k = 0; k < 4; k++) begin : g_dim
    assign dim[k]    = shape[k*DIM_W +: DIM_W];
    assign dim_nz[k] = (dim[k] != '0);
    if (k == 0) begin : g_first
      assign prod[k] = CNT_W'(dim[k]);
    end else begin : g_next
      assign prod[k] = prod[k-1] * CNT_W'(dim[k]);
    end
  end

  logic op_ok, sel_ok;
  assign op_ok    = (op == OPC_SUM) || (op == OPC_MAX);
  assign sel_ok   = !sel[2];
  assign ok       = op_ok && sel_ok && (&dim_nz);
  assign is_max   = (op == OPC_MAX);
  assign grp_size = prod[sel[1:0]];
  assign total    = prod[3];
endmodule

// File: rtl/bf16r_counter.sv
module bf16r_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             fire,
  input  logic [CNT_W-1:0] grp_size,
  input  logic [CNT_W-1:0] total,
  output logic             last_grp,
  output logic             last_all
);
  logic [CNT_W-1:0] grp_cnt, tot_cnt;

  assign last_grp = (grp_cnt == grp_size - CNT_W'(1));
  assign last_all = (tot_cnt == total - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_cnt <= '0;
      tot_cnt <= '0;
    end else if (clear) begin
      grp_cnt <= '0;
      tot_cnt <= '0;
    end else if (fire) begin
      grp_cnt <= last_grp ? '0 : grp_cnt + CNT_W'(1);
      tot_cnt <= tot_cnt + CNT_W'(1);
    end
  end

  AST_GRP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (grp_cnt < grp_size)); // R2
endmodule

// File: rtl/bf16r_accum.sv
module bf16r_accum
  import bf16r_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fire,
  input  logic [15:0] elem,
  input  logic        is_max,
  input  logic        neg,
  input  logic        fmt32,
  input  logic        last_grp,
  output logic        out_valid,
  output logic [31:0] out_data
);
  logic [31:0] acc;
  logic        first;
  logic [31:0] x, step, fin;
  logic        acc_nan;

  assign x       = bf16_widen(elem);
  assign step    = first ? x : (is_max ? f32_max_step(acc, x) : f32_add(acc, x));
  assign acc_nan = f32_is_nan(acc);

  always_comb begin
    if (f32_is_nan(step)) fin = QNAN32;
    else if (neg)         fin = {~step[31], step[30:0]};
    else                  fin = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      first     <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        first <= 1'b1;
      end else if (fire) begin
        if (last_grp) begin
          out_valid <= 1'b1;
          out_data  <= fmt32 ? fin : {16'd0, f32_to_bf16(fin)};
          first     <= 1'b1;
        end else begin
          acc   <= step;
          first <= 1'b0;
        end
      end
    end
  end

  AST_BF16_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fmt32) |-> (out_data[31:16] == 16'd0)); // R4
  AST_NAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !first && is_max && acc_nan && !last_grp && !start) |=> acc_nan); // R6
endmodule

// File: rtl/bf16_reduce_unit.sv
module bf16_reduce_unit #(
  parameter int DIM_W = 8,
  localparam int CNT_W = 4 * DIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [7:0]         cmd_op,
  input  logic [2:0]         cmd_sel,
  input  logic [4*DIM_W-1:0] cmd_shape,
  input  logic               cmd_neg,
  input  logic               cmd_fp32,
  output logic               cmd_err,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_data,
  output logic               out_valid,
  output logic [31:0]        out_data
);
  logic             busy;
  logic             chk_ok, chk_max;
  logic [CNT_W-1:0] chk_grp, chk_total;
  logic             r_max, r_neg, r_fmt32;
  logic [CNT_W-1:0] r_grp, r_total;
  logic             cmd_fire, start, in_fire;
  logic             last_grp, last_all;

  assign cmd_ready = !busy;
  assign in_ready  = busy;
  assign cmd_fire  = cmd_valid && !busy;
  assign start     = cmd_fire && chk_ok;
  assign in_fire   = in_valid && busy;

  bf16r_cmd_check #(.DIM_W(DIM_W)) u_check (
    .op(cmd_op), .sel(cmd_sel), .shape(cmd_shape),
    .ok(chk_ok), .is_max(chk_max), .grp_size(chk_grp), .total(chk_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cmd_err <= 1'b0;
      r_max   <= 1'b0;
      r_neg   <= 1'b0;
      r_fmt32 <= 1'b0;
      r_grp   <= '0;
      r_total <= '0;
    end else begin
      cmd_err <= cmd_fire && !chk_ok;
      if (start) begin
        busy    <= 1'b1;
        r_max   <= chk_max;
        r_neg   <= cmd_neg;
        r_fmt32 <= cmd_fp32;
        r_grp   <= chk_grp;
        r_total <= chk_total;
      end else if (in_fire && last_all) begin
        busy <= 1'b0;
      end
    end
  end

  bf16r_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(start), .active(busy), .fire(in_fire),
    .grp_size(r_grp), .total(r_total), .last_grp(last_grp), .last_all(last_all)
  );

  bf16r_accum u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(in_fire), .elem(in_data),
    .is_max(r_max), .neg(r_neg), .fmt32(r_fmt32), .last_grp(last_grp),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !busy); // R8
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !out_valid); // R8
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && last_all) |=> !busy); // R9
  AST_OUT_AFTER_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_fire)); // R2
endmodule

// File: tb/bf16_reduce_unit_bench.sv
module bf16_reduce_unit_bench;
  localparam int DIM_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = 8'h0;
  logic [2:0] cmd_sel = 3'd0;
  logic [4*DIM_W-1:0] cmd_shape = '0;
  logic cmd_neg = 1'b0;
  logic cmd_fp32 = 1'b0;
  logic cmd_err;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_data = 16'h0;
  logic out_valid;
  logic [31:0] out_data;

  int ntests = 0;
  int nfail = 0;
  int nres = 0;
  logic [31:0] res [0:31];
  logic [15:0] stim [0:31];

  always #10 clk = ~clk;

  bf16_reduce_unit #(.DIM_W(DIM_W)) u_bf16_reduce_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_shape(cmd_shape), .cmd_neg(cmd_neg),
    .cmd_fp32(cmd_fp32), .cmd_err(cmd_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (out_valid && nres < 32) begin
      res[nres] = out_data;
      nres = nres + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    ntests++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic go(input logic [7:0] op, input logic [2:0] sel,
                    input logic [7:0] dx, input logic [7:0] dy,
                    input logic [7:0] dz, input logic [7:0] dw,
                    input logic neg, input logic fp32, input int n);
    nres = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    cmd_shape = {dw, dz, dy, dx}; cmd_neg = neg; cmd_fp32 = fp32;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = stim[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R9 reset in_ready", 32'(in_ready), 32'd0);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset cmd_err", 32'(cmd_err), 32'd0);
    nres = 0;
    in_valid = 1'b1; in_data = 16'h4000;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R9 idle elements ignored", 32'(nres), 32'd0);
  endtask

  task automatic t_sum_x;
    stim[0] = 16'h3F80; stim[1] = 16'h4000; stim[2] = 16'h4040; stim[3] = 16'h4080;
    stim[4] = 16'h3F00; stim[5] = 16'h3F00; stim[6] = 16'h3F80; stim[7] = 16'h4000;
    go(8'h8C, 3'd0, 8'd4, 8'd2, 8'd1, 8'd1, 1'b0, 1'b1, 8);
    chk("R2 sum X count", 32'(nres), 32'd2);
    chk("R1 sum X group0", res[0], 32'h4120_0000);
    chk("R4 sum X group1 fp32", res[1], 32'h4080_0000);
    chk("R9 back to idle", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_sum_xy_neg;
    stim[0] = 16'h3F80; stim[1] = 16'h4000; stim[2] = 16'h4040; stim[3] = 16'h4080;
    go(8'h8C, 3'd1, 8'd2, 8'd2, 8'd1, 8'd1, 1'b1, 1'b0, 4);
    chk("R2 sum XY count", 32'(nres), 32'd1);
    chk("R3 negated bf16 sum", res[0], 32'h0000_C120);
  endtask

  task automatic t_max_xyz;
    stim[0] = 16'hC040; stim[1] = 16'h40A0; stim[2] = 16'h4000; stim[3] = 16'hBF80;
    go(8'h8D, 3'd2, 8'd2, 8'd1, 8'd2, 8'd1, 1'b0, 1'b0, 4);
    chk("R1 max XYZ count", 32'(nres), 32'd1);
    chk("R1 max XYZ value", res[0], 32'h0000_40A0);
    go(8'h8D, 3'd2, 8'd2, 8'd1, 8'd2, 8'd1, 1'b1, 1'b1, 4);
    chk("R3 negated fp32 max", res[0], 32'hC0A0_0000);
  endtask

  task automatic t_nan;
    stim[0] = 16'h3F80; stim[1] = 16'h7FC1; stim[2] = 16'h4040;
    go(8'h8D, 3'd0, 8'd3, 8'd1, 8'd1, 8'd1, 1'b1, 1'b1, 3);
    chk("R6 max NaN canonical, R3 not negated", res[0], 32'h7FC0_0000);
    stim[0] = 16'h7F80; stim[1] = 16'hFF80;
    go(8'h8C, 3'd0, 8'd2, 8'd1, 8'd1, 8'd1, 1'b0, 1'b1, 2);
    chk("R6 inf minus inf", res[0], 32'h7FC0_0000);
  endtask

  task automatic t_zeros;
    stim[0] = 16'h0000; stim[1] = 16'h8000; stim[2] = 16'h8000; stim[3] = 16'h0000;
    go(8'h8D, 3'd0, 8'd2, 8'd2, 8'd1, 8'd1, 1'b0, 1'b0, 4);
    chk("R7 +0 first kept", res[0], 32'h0000_0000);
    chk("R7 -0 first kept", res[1], 32'h0000_8000);
  endtask

  task automatic t_round;
    stim[0] = 16'h3F80; stim[1] = 16'h3B80; stim[2] = 16'h3F81; stim[3] = 16'h3B80;
    go(8'h8C, 3'd0, 8'd2, 8'd2, 8'd1, 8'd1, 1'b0, 1'b0, 4);
    chk("R5 tie to even down", res[0], 32'h0000_3F80);
    chk("R5 tie to even up", res[1], 32'h0000_3F82);
    go(8'h8C, 3'd0, 8'd2, 8'd2, 8'd1, 8'd1, 1'b0, 1'b1, 4);
    chk("R5 fp32 keeps low bits", res[0], 32'h3F80_8000);
    stim[0] = 16'h4380; stim[1] = 16'h3F80; stim[2] = 16'hC380;
    go(8'h8C, 3'd0, 8'd3, 8'd1, 8'd1, 8'd1, 1'b0, 1'b1, 3);
    chk("R5 cancellation", res[0], 32'h3F80_0000);
  endtask

  task automatic t_all_dims;
    for (int i = 0; i < 16; i++) stim[i] = 16'h3F80;
    go(8'h8C, 3'd3, 8'd2, 8'd2, 8'd2, 8'd2, 1'b0, 1'b1, 16);
    chk("R2 XYZW count", 32'(nres), 32'd1);
    chk("R2 XYZW sum", res[0], 32'h4180_0000);
    go(8'h8C, 3'd0, 8'd2, 8'd2, 8'd2, 8'd2, 1'b0, 1'b1, 16);
    chk("R2 X on 4-D count", 32'(nres), 32'd8);
    chk("R2 X on 4-D last", res[7], 32'h4000_0000);
  endtask

  task automatic t_err_one(input string req, input logic [7:0] op, input logic [2:0] sel,
                           input logic [7:0] dz);
    nres = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_shape = {8'd1, dz, 8'd1, 8'd2};
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " cmd_err"}, 32'(cmd_err), 32'd1);
    chk({req, " still ready"}, 32'(cmd_ready), 32'd1);
    in_valid = 1'b1; in_data = 16'h3F80;
    @(negedge clk);
    chk({req, " err one cycle"}, 32'(cmd_err), 32'd0);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    chk({req, " no result"}, 32'(nres), 32'd0);
  endtask

  task automatic t_errors;
    t_err_one("R8 zero dim", 8'h8C, 3'd0, 8'd0);
    t_err_one("R8 bad selector", 8'h8C, 3'd5, 8'd1);
    t_err_one("R8 R1 bad opcode", 8'h8E, 3'd0, 8'd1);
  endtask

  task automatic t_subnormal;
    stim[0] = 16'h0001; stim[1] = 16'h0001;
    go(8'h8C, 3'd0, 8'd2, 8'd1, 8'd1, 8'd1, 1'b0, 1'b1, 2);
    chk("R10 subnormal sum", res[0], 32'h0000_0000);
    stim[0] = 16'h0001; stim[1] = 16'h0000;
    go(8'h8D, 3'd0, 8'd2, 8'd1, 8'd1, 8'd1, 1'b0, 1'b0, 2);
    chk("R10 subnormal max", res[0], 32'h0000_0000);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    ntests++;
    nfail++;
    $display("FAIL watchdog expired got hang expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sum_x();
    t_sum_xy_neg();
    t_max_xyz();
    t_nan();
    t_zeros();
    t_round();
    t_all_dims();
    t_errors();
    t_subnormal();
    finish_up();
  end
endmodule